// File: doc/BRIEF.md
# Match-Driven Multi-Channel PWM Timer

This block is a free-running timer for generating pulse-width-modulated waveforms. A prescaler divides the clock. The divided tick advances a counter. Four compare registers watch that counter. On a tick where the counter equals a compare value, the matching compare register can return the counter to zero, halt counting, or raise a pending flag. The same equality events also set and clear a chain of PWM outputs. Output k is cleared by compare k. It is set either by compare 0 (single-edge mode) or by compare k-1 (double-edge mode). This lets software choose, for each output, a pulse anchored to the start of the period or a pulse whose leading and trailing edges are both placed freely.

Two capture inputs are synchronised and watched for edges. A selected edge copies the counter into a read-only capture register and may raise a flag. Software reaches every register through a word-addressed port with a write strobe and a combinational read path. Pending flags are cleared by writing ones, and any pending flag drives the interrupt output.

Top module: `pwm_match_timer`

## Requirements
- R1: While the run bit (bit 0 of the control word, address 0) is set, the prescale counter (address 2) counts up each clock. The counter (address 1) advances by one on every clock where the prescale counter is at or above the prescale value (address 3), and the prescale counter returns to 0 on that clock. The counter therefore advances once every prescale+1 clocks.
- R2: While the hold-clear bit (bit 1 of the control word) is set, the counter and the prescale counter are held at 0. While the run bit is 0, both keep their values.
- R3: The counter and the prescale counter can be written and read back through their addresses.
- R4: A compare event happens on an advancing clock where the counter equals compare register i (addresses 8+i). If the reset bit for i (bit 3i+1 of the compare-action word, address 4) is set, the counter becomes 0 instead of advancing.
- R5: If the halt bit for compare i (bit 3i+2 of address 4) is set, a compare event on i clears the run bit, and the counter keeps the compare value.
- R6: If the flag bit for compare i (bit 3i of address 4) is set, a compare event on i sets pending flag i (bit i of address 7). Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. The interrupt output is high while any flag is pending.
- R7: Output k (pwmOut[k-1], k = 1..3) in single-edge mode (bit k-1 of the mode word, address 5, is 0) is set by a compare-0 event and cleared by a compare-k event. The high time is (compare k + 1)·(prescale+1) clocks, and the period is (compare 0 + 1)·(prescale+1) clocks when compare 0 resets the counter.
- R8: Output k in double-edge mode (mode bit k-1 = 1) is set by a compare k-1 event and cleared by a compare-k event. The high time is (compare k − compare k-1)·(prescale+1) clocks.
- R9: When an output's set event and clear event happen on the same clock, the output goes low.
- R10: For capture input j, bit 3j of the capture-control word (address 6) selects rising edges, bit 3j+1 selects falling edges, and bit 3j+2 enables flag 4+j. A selected edge, seen after a two-flop synchroniser, loads the counter value into capture register j (address 12+j). An edge that is not selected leaves that register and its flag unchanged.
- R11: After reset, every register reads 0, all outputs are low and the interrupt output is low.
- R12: Writes to the capture registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Word address for reads and writes |
| regWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| capIn | input | 2 | Asynchronous capture inputs |
| pwmOut | output | 3 | PWM outputs 1 to 3 |
| irq | output | 1 | High while any pending flag is set |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, four compare registers driving three outputs, and two capture inputs. With these values, every chaining case in one configuration can be tested: a double-edge output whose set and clear both come from other compare registers, next to single-edge outputs anchored on compare 0. Random trials keep the prescale value below 4 and the compare values below 16. Each PWM period then lasts a few dozen clocks, so many random configurations can be measured for high time and period. Directed cases cover capture of arbitrary 32-bit counter values, coincident set and clear, and halting on a compare.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  // Register word addresses; compare registers follow ADR_MATCH_BASE,
  // capture registers follow the compare registers.
  localparam int unsigned ADR_CTRL       = 0;
  localparam int unsigned ADR_COUNT      = 1;
  localparam int unsigned ADR_PCNT       = 2;
  localparam int unsigned ADR_PSCALE     = 3;
  localparam int unsigned ADR_MATCTL     = 4;
  localparam int unsigned ADR_MODE       = 5;
  localparam int unsigned ADR_CAPCTL     = 6;
  localparam int unsigned ADR_FLAGS      = 7;
  localparam int unsigned ADR_MATCH_BASE = 8;

  // Strobes from control to the counting datapath
  typedef struct packed {
    logic run;
    logic clr;
    logic tcWr;
    logic pcWr;
    logic matchRst;
    logic matchStop;
  } cntStrobe_t;
endpackage

// File: rtl/pwmt_datapath.sv
module pwmt_datapath
  import pwmt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4,
  parameter int NUM_CAP   = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  cntStrobe_t                        stb,
  input  logic [CNT_W-1:0]                  wrData,
  input  logic [CNT_W-1:0]                  pscale,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0]   matchVals,
  input  logic [NUM_CAP-1:0]                capIn,
  input  logic [NUM_CAP-1:0]                capRise,
  input  logic [NUM_CAP-1:0]                capFall,
  output logic [CNT_W-1:0]                  count,
  output logic [CNT_W-1:0]                  pcnt,
  output logic [NUM_MATCH-1:0]              matchHit,
  output logic [NUM_CAP-1:0]                capHit,
  output logic [NUM_CAP-1:0][CNT_W-1:0]     capVals
);

  logic tick;
  logic [NUM_CAP-1:0] syncA, syncB, prevS;

  assign tick = stb.run && !stb.clr && (pcnt >= pscale);

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
    assign matchHit[i] = tick && (count == matchVals[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      pcnt  <= '0;
    end else if (stb.clr) begin
      count <= '0;
      pcnt  <= '0;
    end else begin
      if (stb.run) begin
        if (tick) begin
          pcnt <= '0;
          if (stb.matchRst)       count <= '0;
          else if (!stb.matchStop) count <= count + CNT_W'(1);
        end else begin
          pcnt <= pcnt + CNT_W'(1);
        end
      end
      if (stb.pcWr) pcnt  <= wrData;
      if (stb.tcWr) count <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevS <= '0;
    end else begin
      syncA <= capIn;
      syncB <= syncA;
      prevS <= syncB;
    end
  end

  assign capHit = (capRise & syncB & ~prevS) | (capFall & ~syncB & prevS);

  for (genvar j = 0; j < NUM_CAP; j++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          capVals[j] <= '0;
      else if (capHit[j]) capVals[j] <= count;
    end

    p_capture_load_r10: assert property (@(posedge clk) disable iff (!rstN)
      capHit[j] |=> capVals[j] == $past(count));
  end

  p_clr_holds_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (count == '0) && (pcnt == '0));

  p_prescale_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.clr && !tick && !stb.tcWr) |=> $stable(count));

  p_match_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && stb.matchRst && !stb.tcWr) |=> count == '0);

endmodule

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl
  import pwmt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4,
  parameter int NUM_CAP   = 2,
  parameter int ADDR_W    = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              wrEn,
  input  logic [CNT_W-1:0]                  wrData,
  output logic [CNT_W-1:0]                  rdData,
  input  logic [CNT_W-1:0]                  count,
  input  logic [CNT_W-1:0]                  pcnt,
  input  logic [NUM_MATCH-1:0]              matchHit,
  input  logic [NUM_CAP-1:0]                capHit,
  input  logic [NUM_CAP-1:0][CNT_W-1:0]     capVals,
  output cntStrobe_t                        stb,
  output logic [CNT_W-1:0]                  pscale,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]   matchVals,
  output logic [NUM_CAP-1:0]                capRise,
  output logic [NUM_CAP-1:0]                capFall,
  output logic [NUM_MATCH-2:0]              pwmOut,
  output logic                              irq
);

  localparam int NUM_OUT  = NUM_MATCH - 1;
  localparam int NUM_FLAG = NUM_MATCH + NUM_CAP;
  localparam int MCTL_W   = 3 * NUM_MATCH;
  localparam int CCTL_W   = 3 * NUM_CAP;
  localparam int CAP_BASE = ADR_MATCH_BASE + NUM_MATCH;

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(ADR_COUNT);
  localparam logic [ADDR_W-1:0] A_PCNT   = ADDR_W'(ADR_PCNT);
  localparam logic [ADDR_W-1:0] A_PSCALE = ADDR_W'(ADR_PSCALE);
  localparam logic [ADDR_W-1:0] A_MATCTL = ADDR_W'(ADR_MATCTL);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(ADR_MODE);
  localparam logic [ADDR_W-1:0] A_CAPCTL = ADDR_W'(ADR_CAPCTL);
  localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(ADR_FLAGS);

  logic                  runBit, clrBit;
  logic [MCTL_W-1:0]     matCtl;
  logic [CCTL_W-1:0]     capCtl;
  logic [NUM_OUT-1:0]    modeR;
  logic [NUM_FLAG-1:0]   flags;
  logic [NUM_MATCH-1:0]  matIrq, matRst, matStop;
  logic [NUM_CAP-1:0]    capIrq;
  logic [NUM_FLAG-1:0]   setMask, clrMask;
  logic [NUM_OUT-1:0]    setV, clrV;

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_mfld
    assign matIrq[i]  = matCtl[3*i];
    assign matRst[i]  = matCtl[3*i+1];
    assign matStop[i] = matCtl[3*i+2];

    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
      (matchHit[i] && matIrq[i]) |=> flags[i]);
  end

  for (genvar j = 0; j < NUM_CAP; j++) begin : g_cfld
    assign capRise[j] = capCtl[3*j];
    assign capFall[j] = capCtl[3*j+1];
    assign capIrq[j]  = capCtl[3*j+2];
  end

  // Output chain: clear from compare k+1, set from compare 0 or compare k
  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    assign setV[k] = modeR[k] ? matchHit[k] : matchHit[0];
    assign clrV[k] = matchHit[k+1];

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      matchHit[k+1] |=> !pwmOut[k]);
    p_single_set_r7: assert property (@(posedge clk) disable iff (!rstN)
      (matchHit[0] && !modeR[k] && !matchHit[k+1]) |=> pwmOut[k]);
    p_double_set_r8: assert property (@(posedge clk) disable iff (!rstN)
      (matchHit[k] && modeR[k] && !matchHit[k+1]) |=> pwmOut[k]);
  end

  always_comb begin
    stb.run       = runBit;
    stb.clr       = clrBit;
    stb.tcWr      = wrEn && (addr == A_COUNT);
    stb.pcWr      = wrEn && (addr == A_PCNT);
    stb.matchRst  = |(matchHit & matRst);
    stb.matchStop = |(matchHit & matStop);
  end

  assign setMask = {capHit & capIrq, matchHit & matIrq};
  assign clrMask = (wrEn && addr == A_FLAGS) ? wrData[NUM_FLAG-1:0] : '0;
  assign irq     = |flags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit    <= 1'b0;
      clrBit    <= 1'b0;
      pscale    <= '0;
      matCtl    <= '0;
      capCtl    <= '0;
      modeR     <= '0;
      flags     <= '0;
      matchVals <= '0;
      pwmOut    <= '0;
    end else begin
      if (wrEn && addr == A_CTRL) begin
        runBit <= wrData[0];
        clrBit <= wrData[1];
      end
      if (stb.matchStop) runBit <= 1'b0;
      if (wrEn && addr == A_PSCALE) pscale <= wrData;
      if (wrEn && addr == A_MATCTL) matCtl <= wrData[MCTL_W-1:0];
      if (wrEn && addr == A_CAPCTL) capCtl <= wrData[CCTL_W-1:0];
      if (wrEn && addr == A_MODE)   modeR  <= wrData[NUM_OUT-1:0];
      for (int i = 0; i < NUM_MATCH; i++)
        if (wrEn && addr == ADDR_W'(ADR_MATCH_BASE + i)) matchVals[i] <= wrData;
      flags  <= (flags & ~clrMask) | setMask;
      pwmOut <= (pwmOut | setV) & ~clrV;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL:   rdData = CNT_W'({clrBit, runBit});
      A_COUNT:  rdData = count;
      A_PCNT:   rdData = pcnt;
      A_PSCALE: rdData = pscale;
      A_MATCTL: rdData = CNT_W'(matCtl);
      A_MODE:   rdData = CNT_W'(modeR);
      A_CAPCTL: rdData = CNT_W'(capCtl);
      A_FLAGS:  rdData = CNT_W'(flags);
      default:  rdData = '0;
    endcase
    for (int i = 0; i < NUM_MATCH; i++)
      if (addr == ADDR_W'(ADR_MATCH_BASE + i)) rdData = matchVals[i];
    for (int j = 0; j < NUM_CAP; j++)
      if (addr == ADDR_W'(CAP_BASE + j)) rdData = capVals[j];
  end

  p_stop_clears_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.matchStop |=> !runBit);

  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_FLAGS && wrData[0] && !setMask[0]) |=> !flags[0]);

endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pwmt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_MATCH = 4,
  parameter int NUM_CAP   = 2,
  parameter int ADDR_W    = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   regWrEn,
  input  logic [CNT_W-1:0]       regWrData,
  output logic [CNT_W-1:0]       regRdData,
  input  logic [NUM_CAP-1:0]     capIn,
  output logic [NUM_MATCH-2:0]   pwmOut,
  output logic                   irq
);

  cntStrobe_t                      stb;
  logic [CNT_W-1:0]                count, pcnt, pscale;
  logic [NUM_MATCH-1:0]            matchHit;
  logic [NUM_CAP-1:0]              capHit, capRise, capFall;
  logic [NUM_MATCH-1:0][CNT_W-1:0] matchVals;
  logic [NUM_CAP-1:0][CNT_W-1:0]   capVals;

  pwmt_ctrl #(
    .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .NUM_CAP(NUM_CAP), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(regAddr), .wrEn(regWrEn), .wrData(regWrData),
    .rdData(regRdData), .count(count), .pcnt(pcnt), .matchHit(matchHit),
    .capHit(capHit), .capVals(capVals), .stb(stb), .pscale(pscale),
    .matchVals(matchVals), .capRise(capRise), .capFall(capFall),
    .pwmOut(pwmOut), .irq(irq)
  );

  pwmt_datapath #(
    .CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .NUM_CAP(NUM_CAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .pscale(pscale),
    .matchVals(matchVals), .capIn(capIn), .capRise(capRise), .capFall(capFall),
    .count(count), .pcnt(pcnt), .matchHit(matchHit), .capHit(capHit),
    .capVals(capVals)
  );

endmodule

// File: tb/pwm_match_timer_tb.sv
module pwm_match_timer_tb;

  localparam logic [3:0] A_CTRL = 4'd0, A_COUNT = 4'd1, A_PCNT = 4'd2, A_PSCALE = 4'd3;
  localparam logic [3:0] A_MATCTL = 4'd4, A_MODE = 4'd5, A_CAPCTL = 4'd6, A_FLAGS = 4'd7;
  localparam logic [3:0] A_M0 = 4'd8, A_M1 = 4'd9, A_M2 = 4'd10, A_M3 = 4'd11;
  localparam logic [3:0] A_CAP0 = 4'd12, A_CAP1 = 4'd13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [1:0]  capIn = '0;
  logic [2:0]  pwmOut;
  logic        irq;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_match_timer u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .capIn(capIn),
    .pwmOut(pwmOut), .irq(irq)
  );

  function automatic int expSingleHigh(int pr, int mk);
    return (mk + 1) * (pr + 1);
  endfunction
  function automatic int expDoubleHigh(int pr, int mPrev, int mk);
    return (mk - mPrev) * (pr + 1);
  endfunction
  function automatic int expPeriod(int pr, int m0);
    return (m0 + 1) * (pr + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Measure high time and period of pwmOut[k], sampled at falling edges
  task automatic measure(input int k, output int hi, output int per);
    int lo = 0;
    int guard = 0;
    hi = 0;
    @(negedge clk);
    while (pwmOut[k] && guard < 2000) begin @(negedge clk); guard++; end
    while (!pwmOut[k] && guard < 2000) begin @(negedge clk); guard++; end
    while (pwmOut[k] && guard < 2000) begin @(negedge clk); hi++; guard++; end
    while (!pwmOut[k] && guard < 2000) begin @(negedge clk); lo++; guard++; end
    per = hi + lo;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int hi, per, highs;
    void'($urandom(32'd24681));

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    for (int a = 0; a < 14; a++) begin
      regRead(4'(a), rd);
      check("R11 register reset", rd, 32'd0);
    end
    check("R11 outputs reset", {29'd0, pwmOut}, 32'd0);
    check("R11 irq reset", {31'd0, irq}, 32'd0);

    // R1: prescale of 2 -> one advance every 3 clocks
    regWrite(A_CTRL, 32'h2);
    regWrite(A_PSCALE, 32'd2);
    regWrite(A_CTRL, 32'h1);
    idle(10);
    regRead(A_COUNT, rd); check("R1 count after 10", rd, 32'd3);
    regRead(A_PCNT, rd);  check("R1 pcnt after 10", rd, 32'd1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    regRead(A_COUNT, rd); check("R1 count after 15", rd, 32'd5);
    regRead(A_PCNT, rd);  check("R1 pcnt after 15", rd, 32'd0);

    // R2: hold-clear while running, then freeze with run off
    regWrite(A_CTRL, 32'h3);
    idle(4);
    regRead(A_COUNT, rd); check("R2 count held at zero", rd, 32'd0);
    regRead(A_PCNT, rd);  check("R2 pcnt held at zero", rd, 32'd0);
    regWrite(A_CTRL, 32'h0);

    // R3: write and read back counters; R2 frozen while not running
    regWrite(A_COUNT, 32'hDEAD_0050);
    regWrite(A_PCNT, 32'd2);
    idle(5);
    regRead(A_COUNT, rd); check("R3/R2 count written and frozen", rd, 32'hDEAD_0050);
    regRead(A_PCNT, rd);  check("R3/R2 pcnt written and frozen", rd, 32'd2);

    // R4, R7, R8: random configurations
    for (int t = 0; t < 8; t++) begin
      int pr, m0, m1, m2, m3;
      pr = int'($urandom % 4);
      m0 = 6 + int'($urandom % 10);
      m1 = 1 + int'($urandom % (m0 - 4));
      m2 = m1 + 1 + int'($urandom % (m0 - 1 - m1));
      m3 = int'($urandom % m0);
      regWrite(A_CTRL, 32'h2);
      regWrite(A_PSCALE, 32'(pr));
      regWrite(A_M0, 32'(m0));
      regWrite(A_M1, 32'(m1));
      regWrite(A_M2, 32'(m2));
      regWrite(A_M3, 32'(m3));
      regWrite(A_MATCTL, 32'h2);   // compare 0 resets the counter
      regWrite(A_MODE, 32'h2);     // output 2 double-edge, 1 and 3 single-edge
      regWrite(A_CTRL, 32'h1);
      measure(0, hi, per);
      check("R7 out1 single high", 32'(hi), 32'(expSingleHigh(pr, m1)));
      check("R4 out1 period", 32'(per), 32'(expPeriod(pr, m0)));
      measure(1, hi, per);
      check("R8 out2 double high", 32'(hi), 32'(expDoubleHigh(pr, m1, m2)));
      check("R4 out2 period", 32'(per), 32'(expPeriod(pr, m0)));
      measure(2, hi, per);
      check("R7 out3 single high", 32'(hi), 32'(expSingleHigh(pr, m3)));
    end

    // R4 directed: counter never exceeds compare 0 with reset enabled
    regWrite(A_CTRL, 32'h2);
    regWrite(A_PSCALE, 32'd0);
    regWrite(A_M0, 32'd5);
    regWrite(A_MATCTL, 32'h2);
    regWrite(A_CTRL, 32'h1);
    highs = 0;
    regAddr = A_COUNT;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (regRdData > 32'd5) highs++;
    end
    check("R4 counter bounded by compare 0", 32'(highs), 32'd0);

    // R9: coincident set and clear -> output stays low
    regWrite(A_CTRL, 32'h2);
    regWrite(A_M0, 32'd4);
    regWrite(A_M1, 32'd4);
    regWrite(A_M2, 32'd4);
    regWrite(A_MODE, 32'h2);
    regWrite(A_CTRL, 32'h1);
    idle(12);
    highs = 0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (pwmOut[0] || pwmOut[1]) highs++;
    end
    check("R9 clear wins on coincidence", 32'(highs), 32'd0);

    // R5: halt on compare 2
    regWrite(A_CTRL, 32'h2);
    regWrite(A_M0, 32'd1000);
    regWrite(A_M2, 32'd7);
    regWrite(A_MATCTL, 32'h100);
    regWrite(A_CTRL, 32'h1);
    idle(20);
    regRead(A_CTRL, rd);  check("R5 run bit cleared", rd, 32'd0);
    regRead(A_COUNT, rd); check("R5 count held at compare", rd, 32'd7);

    // R6: flag, write-one-to-clear, irq
    regWrite(A_FLAGS, 32'h3F);
    regWrite(A_CTRL, 32'h2);
    regWrite(A_PSCALE, 32'd1);
    regWrite(A_M1, 32'd3);
    regWrite(A_MATCTL, 32'h8);
    regWrite(A_CTRL, 32'h1);
    idle(20);
    regWrite(A_CTRL, 32'h0);
    @(negedge clk);
    check("R6 irq raised", {31'd0, irq}, 32'd1);
    regRead(A_FLAGS, rd); check("R6 flag 1 pending", rd, 32'h2);
    regWrite(A_FLAGS, 32'h1);
    regRead(A_FLAGS, rd); check("R6 write of other bit keeps flag", rd, 32'h2);
    regWrite(A_FLAGS, 32'h2);
    regRead(A_FLAGS, rd); check("R6 flag cleared", rd, 32'h0);
    check("R6 irq dropped", {31'd0, irq}, 32'd0);

    // R10: captures
    regWrite(A_MATCTL, 32'h0);
    regWrite(A_COUNT, 32'd1234);
    regWrite(A_CAPCTL, 32'h15);   // cap0 rise+flag, cap1 fall only
    capIn[0] = 1'b1;
    idle(5);
    regRead(A_CAP0, rd);  check("R10 cap0 rise captured", rd, 32'd1234);
    regRead(A_FLAGS, rd); check("R10 cap0 flag set", rd, 32'h10);
    capIn[1] = 1'b1;
    idle(5);
    regRead(A_CAP1, rd);  check("R10 cap1 rise ignored", rd, 32'd0);
    regWrite(A_COUNT, 32'd77);
    capIn[1] = 1'b0;
    idle(5);
    regRead(A_CAP1, rd);  check("R10 cap1 fall captured", rd, 32'd77);
    regRead(A_FLAGS, rd); check("R10 cap1 no flag", rd, 32'h10);
    regWrite(A_COUNT, 32'd88);
    capIn[0] = 1'b0;
    idle(5);
    regRead(A_CAP0, rd);  check("R10 cap0 fall ignored", rd, 32'd1234);

    // R12: capture registers ignore writes
    regWrite(A_CAP0, 32'd999);
    regWrite(A_CAP1, 32'd555);
    regRead(A_CAP0, rd);  check("R12 cap0 read-only", rd, 32'd1234);
    regRead(A_CAP1, rd);  check("R12 cap1 read-only", rd, 32'd77);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule